// File: doc/BRIEF.md
# I2C Bus Condition Status Monitor

This block listens to the clock and data lines of an I2C bus and keeps four status flags for a controller: start seen, stop seen, acknowledge seen, and bus busy. It never drives the bus. Both lines pass through two-flop synchronizers on the system clock. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A bit counter runs from 1 to 9 and restarts on every start. The counter marks the ninth clock of each byte, where the acknowledge is sampled, and the first clock of each following byte, which clears some flags.

Software reaches the block through a single write port. The write carries four bits: an enable bit, a release-communication strobe, a start-enable configuration bit and a reservation configuration bit. The start-enable bit sets the value the busy flag takes when the block is switched on. The reservation bit is only stored and read back. Both configuration bits are locked while the block is enabled.

Top module: `i2c_cond_monitor`

## Requirements
- R1: A start condition (SDA falling while SCL is high) sets `st_start` and `st_busy`.
- R2: A stop condition (SDA rising while SCL is high) sets `st_stop` and clears `st_start`, `st_ack` and `st_busy`.
- R3: `st_ack` is set when SDA is low at the rising edge of the ninth SCL clock of a byte. It stays clear when SDA is high there.
- R4: `st_ack` clears at the first SCL rising edge of the next byte.
- R5: `st_start` stays set through the whole address byte, including its ninth clock. It clears at the first SCL rising edge of the byte that follows the address byte.
- R6: `st_stop` is not cleared by a later start alone. It clears at the first SCL rising edge of the address byte that follows that start.
- R7: A write with `reg_wdata[1]`=1 (the release strobe) clears `st_start` and `st_ack`. It leaves `st_stop` and `st_busy` unchanged.
- R8: Writing the enable bit `reg_wdata[0]`=0 clears all four flags. While the block is disabled, bus conditions leave every flag at 0.
- R9: The configuration bits `reg_wdata[2]` (start-enable) and `reg_wdata[3]` (reservation) are stored only if the block is disabled when the write occurs. Reset clears the enable bit and both configuration bits.
- R10: When the block is enabled, `st_busy` becomes 0 if start-enable is 1, and 1 if start-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line (asynchronous) |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Bit 0 enable, bit 1 release strobe, bit 2 start-enable, bit 3 reservation |
| st_start | output | 1 | Start detected / address phase |
| st_stop | output | 1 | Stop detected |
| st_ack | output | 1 | Acknowledge detected |
| st_busy | output | 1 | Bus busy (read-only) |
| st_enable | output | 1 | Enable bit readback |
| cfg_start_en | output | 1 | Start-enable configuration readback |
| cfg_resv | output | 1 | Reservation configuration readback |

## Verification
If the bit counter is off by one, `st_ack` and `st_start` change state one bus clock early or late. This appears within a single bit time after the affected byte boundary. If the start-since-stop tracking is wrong, `st_stop` clears either on the start itself or never. This is visible as soon as the first address clock arrives. A broken configuration lock or disable path appears on the readback pins and flags one cycle after the offending write.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int unsigned REG_W       = 4;
  localparam int unsigned BIT_ENABLE  = 0;
  localparam int unsigned BIT_RELEASE = 1;
  localparam int unsigned BIT_STEN    = 2;
  localparam int unsigned BIT_RESV    = 3;

  typedef struct packed {
    logic start_evt;
    logic stop_evt;
    logic scl_rise;
  } bus_evt_t;

  typedef struct packed {
    logic ninth_rise;
    logic next_first;
    logic addr_first;
    logic post_addr_first;
  } byte_evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '1;
      else     chain_q <= {chain_q[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl,
  input  logic     sda,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    evt.start_evt = scl & scl_q & sda_q & ~sda;
    evt.stop_evt  = scl & scl_q & ~sda_q & sda;
    evt.scl_rise  = scl & ~scl_q;
  end
endmodule

// File: rtl/i2c_byte_tracker.sv
module i2c_byte_tracker
  import i2c_mon_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  bus_evt_t  evt,
  output byte_evt_t bev,
  output logic [$clog2(DATA_BITS+2)-1:0] cnt
);
  localparam int unsigned SLOTS = DATA_BITS + 1;
  localparam int unsigned CW    = $clog2(DATA_BITS + 2);
  localparam logic [CW-1:0] LAST = CW'(SLOTS);
  localparam logic [CW-1:0] PREV = CW'(SLOTS - 1);

  logic [CW-1:0] cnt_q;
  logic          frame_q;
  logic          addr_q;
  logic          rise_in;

  assign rise_in = evt.scl_rise & frame_q;

  always_ff @(posedge clk) begin
    if (rst || !en || evt.stop_evt) begin
      cnt_q   <= '0;
      frame_q <= 1'b0;
      addr_q  <= 1'b0;
    end else if (evt.start_evt) begin
      cnt_q   <= '0;
      frame_q <= 1'b1;
      addr_q  <= 1'b1;
    end else if (rise_in) begin
      if (cnt_q == LAST) begin
        cnt_q  <= CW'(1);
        addr_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  always_comb begin
    bev.ninth_rise      = rise_in && (cnt_q == PREV);
    bev.next_first      = rise_in && (cnt_q == LAST);
    bev.addr_first      = rise_in && (cnt_q == '0);
    bev.post_addr_first = bev.next_first && addr_q;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2c_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      en_rise,
  input  logic      release_p,
  input  logic      start_en,
  input  logic      sda,
  input  bus_evt_t  evt,
  input  byte_evt_t bev,
  output logic      f_start,
  output logic      f_stop,
  output logic      f_ack,
  output logic      f_busy
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      f_start <= 1'b0;
      f_stop  <= 1'b0;
      f_ack   <= 1'b0;
      f_busy  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (en_rise) f_busy <= ~start_en;
      if (evt.start_evt) begin
        f_start <= 1'b1;
        f_busy  <= 1'b1;
        pend_q  <= 1'b1;
      end
      if (evt.stop_evt) begin
        f_stop  <= 1'b1;
        f_start <= 1'b0;
        f_ack   <= 1'b0;
        f_busy  <= 1'b0;
        pend_q  <= 1'b0;
      end
      if (bev.ninth_rise && !sda) f_ack <= 1'b1;
      if (bev.next_first)          f_ack <= 1'b0;
      if (bev.post_addr_first)     f_start <= 1'b0;
      if (bev.addr_first && pend_q) begin
        f_stop <= 1'b0;
        pend_q <= 1'b0;
      end
      if (release_p) begin
        f_start <= 1'b0;
        f_ack   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
  import i2c_mon_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             st_start,
  output logic             st_stop,
  output logic             st_ack,
  output logic             st_busy,
  output logic             st_enable,
  output logic             cfg_start_en,
  output logic             cfg_resv
);
  localparam int unsigned CW = $clog2(DATA_BITS + 2);

  logic [1:0]    line_s;
  bus_evt_t      evt;
  byte_evt_t     bev;
  logic [CW-1:0] bit_cnt;
  logic          en_q, en_d, sten_q, resv_q, rel_q;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({scl_in, sda_in}), .dout(line_s)
  );

  i2c_cond_detect u_det (
    .clk(clk), .rst(rst), .scl(line_s[1]), .sda(line_s[0]), .evt(evt)
  );

  i2c_byte_tracker #(.DATA_BITS(DATA_BITS)) u_track (
    .clk(clk), .rst(rst), .en(en_q), .evt(evt), .bev(bev), .cnt(bit_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      en_d   <= 1'b0;
      sten_q <= 1'b0;
      resv_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      en_d  <= en_q;
      rel_q <= reg_we & reg_wdata[BIT_RELEASE];
      if (reg_we) begin
        en_q <= reg_wdata[BIT_ENABLE];
        if (!en_q) begin
          sten_q <= reg_wdata[BIT_STEN];
          resv_q <= reg_wdata[BIT_RESV];
        end
      end
    end
  end

  i2c_status_flags u_flags (
    .clk(clk), .rst(rst), .en(en_q), .en_rise(en_q & ~en_d),
    .release_p(rel_q), .start_en(sten_q), .sda(line_s[0]),
    .evt(evt), .bev(bev),
    .f_start(st_start), .f_stop(st_stop), .f_ack(st_ack), .f_busy(st_busy)
  );

  assign st_enable    = en_q;
  assign cfg_start_en = sten_q;
  assign cfg_resv     = resv_q;
endmodule

// File: rtl/i2c_cond_monitor_chk.sv
module i2c_cond_monitor_chk #(
  parameter int unsigned CW = 4,
  parameter int unsigned LIMIT = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          st_start,
  input logic          st_stop,
  input logic          st_ack,
  input logic          st_busy,
  input logic          st_enable,
  input logic          cfg_start_en,
  input logic          cfg_resv,
  input logic [CW-1:0] bit_cnt
);
  AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(st_start) |-> st_busy); // R1
  AST_STOP_CLEARS_REST: assert property (@(posedge clk) disable iff (rst)
    $rose(st_stop) |-> (!st_start && !st_ack && !st_busy)); // R2
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !st_enable |=> (!st_start && !st_stop && !st_ack && !st_busy)); // R8
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    st_enable |=> ($stable(cfg_start_en) && $stable(cfg_resv))); // R9
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CW'(LIMIT)); // R3
endmodule

bind i2c_cond_monitor i2c_cond_monitor_chk #(
  .CW($clog2(DATA_BITS + 2)), .LIMIT(DATA_BITS + 1)
) u_chk (
  .clk(clk), .rst(rst), .st_start(st_start), .st_stop(st_stop),
  .st_ack(st_ack), .st_busy(st_busy), .st_enable(st_enable),
  .cfg_start_en(cfg_start_en), .cfg_resv(cfg_resv), .bit_cnt(bit_cnt)
);

// File: tb/test_i2c_cond_monitor.sv
module test_i2c_cond_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1;
  logic reg_we = 1'b0;
  logic [3:0] reg_wdata = '0;
  logic st_start, st_stop, st_ack, st_busy, st_enable, cfg_start_en, cfg_resv;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  localparam int Q = 6;

  typedef struct {
    string      tag;
    logic [6:0] exp;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  i2c_cond_monitor i_i2c_cond_monitor (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
    .reg_we(reg_we), .reg_wdata(reg_wdata),
    .st_start(st_start), .st_stop(st_stop), .st_ack(st_ack), .st_busy(st_busy),
    .st_enable(st_enable), .cfg_start_en(cfg_start_en), .cfg_resv(cfg_resv)
  );

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [6:0] act;
      it  = sb.pop_front();
      act = {st_start, st_stop, st_ack, st_busy, st_enable, cfg_start_en, cfg_resv};
      vectors++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got %b expected %b (start stop ack busy en sten resv)",
                 it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_st(input string tag, input logic [6:0] e);
    sb.push_back('{tag, e});
    repeat (2) @(posedge clk);
  endtask

  task automatic wait_q(input int n);
    repeat (n * Q) @(posedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_wdata = '0;
    repeat (4) @(posedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; wait_q(1); scl = 1'b1; wait_q(1);
    sda = 1'b0; wait_q(1); scl = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop();
    sda = 1'b0; wait_q(1); scl = 1'b1; wait_q(1);
    sda = 1'b1; wait_q(1);
  endtask

  task automatic bus_bit(input logic b);
    sda = b; wait_q(1); scl = 1'b1; wait_q(2); scl = 1'b0; wait_q(1);
  endtask

  task automatic bus_bits(input int n);
    for (int i = 0; i < n; i++) bus_bit(i[0]);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    repeat (2) @(posedge clk);
    expect_st("R9 reset state", 7'b0000_000);

    wr(4'b0001);
    expect_st("R10 enable with start-enable 0 gives busy", 7'b0001_100);
    wr(4'b0000);
    wr(4'b0100);
    wr(4'b0101);
    expect_st("R10 enable with start-enable 1 gives idle", 7'b0000_110);
    wr(4'b1001);
    expect_st("R9 config write ignored while enabled", 7'b0000_110);

    bus_start();
    expect_st("R1 start sets start and busy", 7'b1001_110);
    bus_bits(8); bus_bit(1'b0);
    expect_st("R3 R5 ack on ninth clock, start held", 7'b1011_110);
    bus_bit(1'b1);
    expect_st("R4 R5 first clock of data byte clears ack and start", 7'b0001_110);
    bus_bits(7); bus_bit(1'b1);
    expect_st("R3 nack leaves ack clear", 7'b0001_110);
    bus_stop();
    expect_st("R2 stop sets stop, clears busy", 7'b0100_110);

    bus_start();
    expect_st("R6 start alone keeps stop flag", 7'b1101_110);
    bus_bit(1'b1);
    expect_st("R6 first address clock clears stop", 7'b1001_110);
    bus_bits(7); bus_bit(1'b0);
    expect_st("R3 ack on second frame", 7'b1011_110);
    wr(4'b0011);
    expect_st("R7 release clears start and ack only", 7'b0001_110);

    bus_bits(8); bus_bit(1'b0);
    expect_st("R3 ack after release", 7'b0011_110);
    bus_stop();
    expect_st("R2 stop clears ack", 7'b0100_110);
    bus_start();
    bus_bits(8); bus_bit(1'b0);
    expect_st("R3 ack in third frame", 7'b1011_110);
    bus_stop();
    expect_st("R2 stop clears start and ack", 7'b0100_110);

    bus_start();
    expect_st("R1 start before disable", 7'b1101_110);
    wr(4'b1000);
    expect_st("R8 disable clears all flags", 7'b0000_010);
    bus_stop();
    bus_start();
    bus_bits(9);
    expect_st("R8 bus ignored while disabled", 7'b0000_010);

    wait (sb.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule